// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block sits in one direction of a two-bus bridge. Transactions arriving from the upstream bus are held in three queues, one each for posted memory writes, delayed read requests and delayed write requests. The block then picks which held entry goes out next on the downstream bus, so that the bridge's passing rules between these classes are never broken. The other direction of the bridge uses a second instance with no shared state, because writes that flow in opposite directions do not need to be ordered against each other.

Each class has its own valid/ready enqueue port. The chosen entry is shown on the issue port together with its class code, and it stays there until the downstream side reports a result. If the result is a completion, the entry is removed from its queue and its place in the order is fixed. If the result is a target retry, the entry stays at the head of its queue and takes part in arbitration again. Posted writes are never combined, merged or collapsed. Every accepted write is issued and completed on its own.

Top module: `txn_order_queue`

## Requirements
- R1: Each enqueue ready is low only while its own queue is full. A full posted-write queue is the only thing that holds off posted-write acceptance: pending delayed requests never do, and a full posted-write queue does not lower the delayed-request readies.
- R2: Posted writes are issued in the order they were accepted. Each accepted write is issued as a separate entry, including writes that carry identical data.
- R3: A delayed read request is never issued while a posted write accepted before it is still pending.
- R4: A pending posted write is issued ahead of an older pending delayed request.
- R5: Delayed read requests leave in acceptance order among themselves, and so do delayed write requests.
- R6: A delayed write request is never issued while a posted write accepted before it is still pending.
- R7: A result with `res_retry`=1 leaves the entry queued. Issue drops for one cycle and then arbitration runs again.
- R8: After a delayed request of one class is retried, the head of the other delayed class is issued first if it is eligible. This lets a delayed read pass an earlier delayed write.
- R9: When neither delayed class is deferred by a retry, the older eligible delayed request is issued first.
- R10: Class codes are 0 = posted write, 1 = delayed read, 2 = delayed write, and 3 is never issued. `iss_valid` rises on the edge after the block is idle and an entry is present. Any result drops `iss_valid` on the next edge. While no result arrives, the issued class and data hold steady.
- R11: After reset, all three readies are high and `iss_valid` is low.
- R12: Entries accepted on the same edge are ordered posted write first, then delayed read, then delayed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Posted write offered |
| pw_data | input | DW | Posted write payload |
| pw_ready | output | 1 | Posted write queue has room |
| rd_valid | input | 1 | Delayed read request offered |
| rd_data | input | DW | Delayed read payload |
| rd_ready | output | 1 | Delayed read queue has room |
| wr_valid | input | 1 | Delayed write request offered |
| wr_data | input | DW | Delayed write payload |
| wr_ready | output | 1 | Delayed write queue has room |
| iss_valid | output | 1 | An entry is being issued downstream |
| iss_class | output | 2 | Class of issued entry (0 PW, 1 RD, 2 WR) |
| iss_data | output | DW | Payload of issued entry |
| res_valid | input | 1 | Result for the issued entry |
| res_retry | input | 1 | Result was target retry (entry stays) |

## Verification
An entry that is accepted on one edge can appear on the issue port at the next edge at the earliest. A result that is given on an edge removes `iss_valid` at the following edge, and the next entry shows up one edge after that. The bench changes inputs on falling edges and samples on falling edges. It waits for `iss_valid` and then checks class and data, and it checks `iss_valid` low on the falling edge just after each result. Held-off ordering is set up by keeping one blocker entry unresolved while the later entries are enqueued behind it.

// File: rtl/txn_order_queue.sv
module txn_order_queue #(
  parameter int DW = 32,
  parameter int SW = 8,
  parameter int PW_DEPTH = 4,
  parameter int RD_DEPTH = 2,
  parameter int WR_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pw_valid,
  input  logic [DW-1:0] pw_data,
  output logic          pw_ready,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          rd_ready,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          iss_valid,
  output logic [1:0]    iss_class,
  output logic [DW-1:0] iss_data,
  input  logic          res_valid,
  input  logic          res_retry
);
  localparam logic [1:0] C_PW = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_NONE = 2'd3;
  localparam int PA = PW_DEPTH > 1 ? $clog2(PW_DEPTH) : 1;
  localparam int RA = RD_DEPTH > 1 ? $clog2(RD_DEPTH) : 1;
  localparam int WA = WR_DEPTH > 1 ? $clog2(WR_DEPTH) : 1;
  localparam int PC = $clog2(PW_DEPTH + 1);
  localparam int RC = $clog2(RD_DEPTH + 1);
  localparam int WC = $clog2(WR_DEPTH + 1);

  function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  logic [SW+DW-1:0] pw_q [PW_DEPTH];
  logic [SW+DW-1:0] rd_q [RD_DEPTH];
  logic [SW+DW-1:0] wr_q [WR_DEPTH];
  logic [PA-1:0] pw_wp, pw_rp;
  logic [RA-1:0] rd_wp, rd_rp;
  logic [WA-1:0] wr_wp, wr_rp;
  logic [PC-1:0] pw_cnt;
  logic [RC-1:0] rd_cnt;
  logic [WC-1:0] wr_cnt;
  logic [SW-1:0] seq, iss_stamp;
  logic [1:0]    defer;

  assign pw_ready = pw_cnt != PC'(PW_DEPTH);
  assign rd_ready = rd_cnt != RC'(RD_DEPTH);
  assign wr_ready = wr_cnt != WC'(WR_DEPTH);

  wire pw_in = pw_valid && pw_ready;
  wire rd_in = rd_valid && rd_ready;
  wire wr_in = wr_valid && wr_ready;
  wire [SW-1:0] pw_st = seq;
  wire [SW-1:0] rd_st = seq + SW'(pw_in);
  wire [SW-1:0] wr_st = seq + SW'(pw_in) + SW'(rd_in);

  wire [SW-1:0] pw_hs = pw_q[pw_rp][SW+DW-1:DW];
  wire [SW-1:0] rd_hs = rd_q[rd_rp][SW+DW-1:DW];
  wire [SW-1:0] wr_hs = wr_q[wr_rp][SW+DW-1:DW];

  wire pw_av = pw_cnt != '0;
  wire rd_av = rd_cnt != '0 && !(pw_av && older(pw_hs, rd_hs));
  wire wr_av = wr_cnt != '0 && !(pw_av && older(pw_hs, wr_hs));

  logic [1:0] pick;
  always_comb begin
    if (pw_av)                pick = C_PW;
    else if (rd_av && wr_av) begin
      if (defer == C_RD)      pick = C_WR;
      else if (defer == C_WR) pick = C_RD;
      else                    pick = older(rd_hs, wr_hs) ? C_RD : C_WR;
    end
    else if (rd_av)           pick = C_RD;
    else if (wr_av)           pick = C_WR;
    else                      pick = C_NONE;
  end

  wire done   = iss_valid && res_valid;
  wire pw_pop = done && !res_retry && iss_class == C_PW;
  wire rd_pop = done && !res_retry && iss_class == C_RD;
  wire wr_pop = done && !res_retry && iss_class == C_WR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_wp <= '0; pw_rp <= '0; pw_cnt <= '0;
      rd_wp <= '0; rd_rp <= '0; rd_cnt <= '0;
      wr_wp <= '0; wr_rp <= '0; wr_cnt <= '0;
      seq <= '0; defer <= C_NONE;
      iss_valid <= 1'b0; iss_class <= C_PW; iss_data <= '0; iss_stamp <= '0;
    end else begin
      seq <= seq + SW'(pw_in) + SW'(rd_in) + SW'(wr_in);
      if (pw_in) begin
        pw_q[pw_wp] <= {pw_st, pw_data};
        pw_wp <= (pw_wp == PA'(PW_DEPTH-1)) ? '0 : pw_wp + 1'b1;
      end
      if (rd_in) begin
        rd_q[rd_wp] <= {rd_st, rd_data};
        rd_wp <= (rd_wp == RA'(RD_DEPTH-1)) ? '0 : rd_wp + 1'b1;
      end
      if (wr_in) begin
        wr_q[wr_wp] <= {wr_st, wr_data};
        wr_wp <= (wr_wp == WA'(WR_DEPTH-1)) ? '0 : wr_wp + 1'b1;
      end
      if (pw_pop) pw_rp <= (pw_rp == PA'(PW_DEPTH-1)) ? '0 : pw_rp + 1'b1;
      if (rd_pop) rd_rp <= (rd_rp == RA'(RD_DEPTH-1)) ? '0 : rd_rp + 1'b1;
      if (wr_pop) wr_rp <= (wr_rp == WA'(WR_DEPTH-1)) ? '0 : wr_rp + 1'b1;
      pw_cnt <= pw_cnt + PC'(pw_in) - PC'(pw_pop);
      rd_cnt <= rd_cnt + RC'(rd_in) - RC'(rd_pop);
      wr_cnt <= wr_cnt + WC'(wr_in) - WC'(wr_pop);

      if (done) begin
        iss_valid <= 1'b0;
        if (iss_class != C_PW) defer <= res_retry ? iss_class : C_NONE;
      end else if (!iss_valid && pick != C_NONE) begin
        iss_valid <= 1'b1;
        iss_class <= pick;
        case (pick)
          C_PW:    {iss_stamp, iss_data} <= pw_q[pw_rp];
          C_RD:    {iss_stamp, iss_data} <= rd_q[rd_rp];
          default: {iss_stamp, iss_data} <= wr_q[wr_rp];
        endcase
      end
    end
  end
endmodule

module txn_order_queue_chk #(
  parameter int DW = 32,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pw_ready,
  input logic          iss_valid,
  input logic [1:0]    iss_class,
  input logic [DW-1:0] iss_data,
  input logic [SW-1:0] iss_stamp,
  input logic          res_valid,
  input logic          res_retry,
  input logic          pw_av,
  input logic [SW-1:0] pw_hs
);
  function automatic logic older(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  // R3
  rd_after_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_class == 2'd1 |-> !(pw_av && older(pw_hs, iss_stamp)));
  // R6
  wr_after_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_class == 2'd2 |-> !(pw_av && older(pw_hs, iss_stamp)));
  // R7
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !res_valid |=> iss_valid && $stable(iss_class) && $stable(iss_data));
  // R10
  result_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && res_valid |=> !iss_valid);
  // R10
  class_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> iss_class != 2'd3);
  // R1
  pw_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && res_valid && !res_retry && iss_class == 2'd0 |=> pw_ready);
endmodule

bind txn_order_queue txn_order_queue_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pw_ready(pw_ready), .iss_valid(iss_valid),
  .iss_class(iss_class), .iss_data(iss_data), .iss_stamp(iss_stamp),
  .res_valid(res_valid), .res_retry(res_retry), .pw_av(pw_av), .pw_hs(pw_hs)
);

// File: tb/txn_order_queue_bench.sv
module txn_order_queue_bench;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0;
  logic pw_valid = 0, rd_valid = 0, wr_valid = 0, res_valid = 0, res_retry = 0;
  logic [DW-1:0] pw_data = '0, rd_data = '0, wr_data = '0;
  logic pw_ready, rd_ready, wr_ready, iss_valid;
  logic [1:0] iss_class;
  logic [DW-1:0] iss_data;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  txn_order_queue u_txn_order_queue (
    .clk(clk), .rst_n(rst_n),
    .pw_valid(pw_valid), .pw_data(pw_data), .pw_ready(pw_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .iss_valid(iss_valid), .iss_class(iss_class), .iss_data(iss_data),
    .res_valid(res_valid), .res_retry(res_retry)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [DW-1:0] d);
    @(negedge clk);
    pw_valid = (c == 0); rd_valid = (c == 1); wr_valid = (c == 2);
    pw_data = d; rd_data = d; wr_data = d;
    @(negedge clk);
    pw_valid = 0; rd_valid = 0; wr_valid = 0;
  endtask

  task automatic take(input logic [1:0] c, input logic [DW-1:0] d, input logic retry, input string tag);
    for (int i = 0; i < 20 && !iss_valid; i++) @(negedge clk);
    check(iss_valid == 1, {tag, " valid"}, iss_valid, 1);
    check(iss_class == c && iss_data == d, tag, {iss_class, iss_data}, {c, d});
    res_valid = 1; res_retry = retry;
    @(negedge clk);
    res_valid = 0; res_retry = 0;
    check(iss_valid == 0, "R10 drop after result", iss_valid, 0);
  endtask

  task automatic t_reset();
    check(pw_ready && rd_ready && wr_ready, "R11 readies", {pw_ready, rd_ready, wr_ready}, 3'b111);
    check(!iss_valid, "R11 idle", iss_valid, 0);
  endtask

  task automatic t_pw_order();
    push(0, 32'hA0); push(0, 32'hA0); push(0, 32'hA1);
    take(0, 32'hA0, 0, "R2 first");
    take(0, 32'hA0, 0, "R2 duplicate kept");
    take(0, 32'hA1, 0, "R2 third");
  endtask

  task automatic t_pw_passes_rd();
    push(0, 32'h50);
    push(1, 32'h51); push(0, 32'h52);
    take(0, 32'h50, 0, "R10 blocker");
    take(0, 32'h52, 0, "R4 pw passes older rd");
    take(1, 32'h51, 0, "R3 rd after pw");
  endtask

  task automatic t_oldest();
    push(0, 32'h60);
    push(2, 32'h61); push(1, 32'h62); push(1, 32'h63);
    take(0, 32'h60, 0, "R6 blocker");
    take(2, 32'h61, 0, "R9 older wr first");
    take(1, 32'h62, 0, "R5 rd order a");
    take(1, 32'h63, 0, "R5 rd order b");
  endtask

  task automatic t_retry_pass();
    push(0, 32'h70);
    push(2, 32'h71); push(1, 32'h72);
    take(0, 32'h70, 0, "R7 blocker");
    take(2, 32'h71, 1, "R7 wr retried");
    take(1, 32'h72, 0, "R8 rd passes retried wr");
    take(2, 32'h71, 0, "R7 wr reissued");
  endtask

  task automatic t_full();
    push(1, 32'h80);
    for (int i = 0; i < 4; i++) push(0, 32'h90 + i);
    check(!pw_ready, "R1 pw full", pw_ready, 0);
    check(rd_ready && wr_ready, "R1 others free", {rd_ready, wr_ready}, 2'b11);
    take(1, 32'h80, 0, "R1 rd blocker");
    for (int i = 0; i < 4; i++) take(0, 32'h90 + i, 0, "R1 pw drain");
    check(pw_ready, "R1 pw room", pw_ready, 1);
  endtask

  task automatic t_random_retry();
    logic [DW-1:0] exp [6] = '{32'hB0, 32'hB1, 32'hB2, 32'hB3, 32'hC0, 32'hC1};
    for (int i = 0; i < 4; i++) push(0, exp[i]);
    push(1, exp[4]); push(1, exp[5]);
    for (int i = 0; i < 6; i++) begin
      logic r;
      do begin
        r = ($urandom % 3) == 0;
        take(i < 4 ? 2'd0 : 2'd1, exp[i], r, i < 4 ? "R2 random retry pw" : "R3 random retry rd");
      end while (r);
    end
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    pw_valid = 1; rd_valid = 1; wr_valid = 1;
    pw_data = 32'hD0; rd_data = 32'hD1; wr_data = 32'hD2;
    @(negedge clk);
    pw_valid = 0; rd_valid = 0; wr_valid = 0;
    take(0, 32'hD0, 0, "R12 pw first");
    take(1, 32'hD1, 0, "R12 rd second");
    take(2, 32'hD2, 0, "R12 wr third");
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pw_order();
    t_pw_passes_rd();
    t_oldest();
    t_retry_pass();
    t_full();
    t_random_retry();
    t_same_cycle();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule